// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block models a synchronous static RAM whose words are divided into byte lanes of nine bits each (eight data bits and one parity bit). Every input is registered on the rising clock edge: address, write data, the three chip selects and the write controls. The array is accessed on the next edge, and read data lands in an output register. Writes can touch any subset of lanes, either through per-lane enables qualified by a lane-write strobe, or all at once through a global write strobe. The default geometry is 256 words of 36 bits so that elaboration stays small. Setting `ADDR_W` to 16 gives the full 65,536-word array.

Read data leaves the block as a stream. `rdata` is qualified by `rdata_vld`. There is no ready input, because the pipeline never stalls. A consumer must take each word in the cycle it is valid, and the word is valid for exactly one cycle per accepted read. `oe_n` gates the valid flag and the data without waiting for a clock edge.

A sleep input powers the block down. While sleep is sampled high, no access is accepted. After sleep drops, a fixed number of edges, `WAKE_CYC`, are still ignored. Reset behaves as if it were a sleep period, so the same wake window follows reset.

Top module: `sram_pipe36`

## Requirements
- R1: A read presented before edge k captures at edge k. Its data appears at `rdata` with `rdata_vld` high after edge k+1 and not after edge k.
- R2: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Under any other combination, no read or write takes place, and `rdata_vld` is low after the second edge.
- R3: Lane n occupies bits [9n+8:9n]: the data byte plus its parity bit in the top position. With `all_wr_n`=1, `lane_wr_n`=0 and `lane_en_n[n]`=0, lane n is written. Lanes whose `lane_en_n` bit is 1 keep their contents.
- R4: With `all_wr_n`=1 and either `lane_wr_n`=1 or all `lane_en_n` bits at 1, the access is a read. In that case `lane_en_n` has no effect on the array.
- R5: With `all_wr_n`=0, all lanes are written whatever `lane_en_n` and `lane_wr_n` are.
- R6: A write never raises `rdata_vld`. Its data is returned by a read captured on the very next edge.
- R7: `rdata_vld` is high only while `oe_n`=0 and a read result is held. It reacts to `oe_n` without a clock edge. `rdata` is all zeros whenever `rdata_vld` is low.
- R8: Sleep sampled high at an edge blocks every access at that edge, including one captured on the previous edge. `rdata_vld` is low after that edge.
- R9: After the last edge that sees sleep high, or the last edge in reset, the next `WAKE_CYC` edges (default 3) accept no access. The edge after them accepts accesses again.
- R10: Writes presented during sleep or during the wake window leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Power-down request, active high |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, lane n in bits [9n+8:9n] |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| lane_wr_n | input | 1 | Qualifies the lane enables, active low |
| all_wr_n | input | 1 | Global write of every lane, active low |
| oe_n | input | 1 | Output enable, active low, unclocked |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data valid for one cycle |

## Verification
The bench sweeps all sixteen lane-enable patterns against all four settings of the lane-write and global-write strobes. Each sweep step starts from a known word, so the merged result shows which lanes moved and which lanes were left untouched. All eight chip-select combinations are tried with both reads and writes, which separates real selection from partial decoding. The sleep sequences sample `rdata_vld` on every edge of the wake window, after reset and after sleep, to pin down the exact count of ignored edges. They also confirm that writes attempted while asleep leave the stored word intact.

// File: rtl/sram_pipe_pkg.sv
`timescale 1ns/1ps
package sram_pipe_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_wake_ctl.sv
`timescale 1ns/1ps
// Counts the edges that must pass after sleep (or reset) before accesses resume.
module sram_wake_ctl #(
  parameter int WAKE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic awake
);
  localparam int CNT_W = $clog2(WAKE_CYC + 2);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAKE_CYC);

  logic [CNT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               wait_q <= LOAD;
    else if (sleep)           wait_q <= LOAD;
    else if (wait_q != '0)    wait_q <= wait_q - 1'b1;
  end

  assign awake = !sleep && (wait_q == '0);
endmodule

// File: rtl/sram_lane_decode.sv
`timescale 1ns/1ps
// Turns the write strobes into a per-lane write mask.
module sram_lane_decode #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] lane_en_n,
  input  logic             lane_wr_n,
  input  logic             all_wr_n,
  output logic [LANES-1:0] mask,
  output logic             is_write
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g] = !all_wr_n || (!lane_wr_n && !lane_en_n[g]);
  end
  assign is_write = |mask;
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
// Storage split into one memory per lane, with a registered read port.
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [LANES-1:0]          mask,
  output logic [LANES*LANE_W-1:0]   dout
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (go && wr && mask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)         dout[g*LANE_W +: LANE_W] <= '0;
      else if (go && !wr) dout[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/sram_pipe36.sv
`timescale 1ns/1ps
module sram_pipe36 #(
  parameter int ADDR_W   = 8,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic                    lane_wr_n,
  input  logic                    all_wr_n,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_vld
);
  import sram_pipe_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  logic               awake;
  logic               selected;
  logic [LANES-1:0]   mask_d;
  logic               wr_d;
  sram_op_e           op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   mask_q;
  logic               exec;
  logic [DATA_W-1:0]  dout;
  logic               en_dly;

  sram_wake_ctl #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .sleep (sleep),
    .awake (awake)
  );

  sram_lane_decode #(.LANES(LANES)) u_dec (
    .lane_en_n (lane_en_n),
    .lane_wr_n (lane_wr_n),
    .all_wr_n  (all_wr_n),
    .mask      (mask_d),
    .is_write  (wr_d)
  );

  assign selected = !sel_a_n && sel_b && !sel_c_n;

  // Input register stage.
  always_ff @(posedge clk) begin
    if (!rst_n)                  op_q <= OP_IDLE;
    else if (selected && awake)  op_q <= wr_d ? OP_WRITE : OP_READ;
    else                         op_q <= OP_IDLE;
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
    mask_q  <= mask_d;
  end

  // Array stage, dropped if sleep arrives in between.
  assign exec = (op_q != OP_IDLE) && awake;

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (exec),
    .wr    (op_q == OP_WRITE),
    .addr  (addr_q),
    .wdata (wdata_q),
    .mask  (mask_q),
    .dout  (dout)
  );

  // Enable-delay register follows the read into the output register.
  always_ff @(posedge clk) begin
    if (!rst_n) en_dly <= 1'b0;
    else        en_dly <= exec && (op_q == OP_READ);
  end

  assign rdata_vld = en_dly && !oe_n;
  assign rdata     = rdata_vld ? dout : '0;
endmodule

// File: rtl/sram_pipe36_chk.sv
`timescale 1ns/1ps
module sram_pipe36_chk #(
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sleep,
  input logic                    sel_a_n,
  input logic                    sel_b,
  input logic                    sel_c_n,
  input logic [LANES-1:0]        lane_en_n,
  input logic                    lane_wr_n,
  input logic                    all_wr_n,
  input logic                    oe_n,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic                    rdata_vld
);
  localparam int QW = $clog2(WAKE_CYC + 4);
  localparam logic [QW-1:0] QLOAD = QW'(WAKE_CYC + 2);

  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk) begin
    if (!rst_n || sleep)      quiet_q <= QLOAD;
    else if (quiet_q != '0)   quiet_q <= quiet_q - 1'b1;
  end

  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_a_n && sel_b && !sel_c_n) |=> ##1 !rdata_vld);

  a_r6_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_wr_n || (!lane_wr_n && lane_en_n != '1)) |=> ##1 !rdata_vld);

  a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rdata_vld);

  a_r9_wake_window: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q != '0) |-> !rdata_vld);

  always_comb begin
    if (rst_n && oe_n) a_r7_oe_gate: assert (!rdata_vld);
    if (rst_n && rdata_vld == 1'b0) a_r7_zero_idle: assert (rdata == '0);
  end
endmodule

bind sram_pipe36 sram_pipe36_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .WAKE_CYC(WAKE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
  .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n),
  .oe_n(oe_n), .rdata(rdata), .rdata_vld(rdata_vld)
);

// File: tb/sram_pipe36_bench.sv
`timescale 1ns/1ps
module sram_pipe36_bench;
  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int WK = 3;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep = 1'b0;
  logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NL-1:0] lane_en_n = '1;
  logic          lane_wr_n = 1'b1, all_wr_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdata_vld;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] ref_mem [NW];

  always #2.5 clk = ~clk;

  sram_pipe36 #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .WAKE_CYC(WK)) u_sram_pipe36 (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .addr(addr), .wdata(wdata), .lane_en_n(lane_en_n),
    .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n), .oe_n(oe_n),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int a, input int k);
    logic [63:0] v;
    v = (64'h9E3779B97F4A7C15 * 64'(k + 1)) ^ (64'(a) << 28);
    return v[DW-1:0];
  endfunction

  function automatic logic [NL-1:0] mask_of(input logic [NL-1:0] en_n, input logic lw_n, input logic aw_n);
    if (!aw_n) return '1;
    if (!lw_n) return ~en_n;
    return '0;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nv, input logic [NL-1:0] m);
    logic [DW-1:0] r;
    r = old;
    for (int i = 0; i < NL; i++)
      if (m[i]) r[i*LW +: LW] = nv[i*LW +: LW];
    return r;
  endfunction

  task automatic go_idle();
    {sel_a_n, sel_b, sel_c_n} = 3'b101;
    lane_en_n = '1; lane_wr_n = 1'b1; all_wr_n = 1'b1;
  endtask

  task automatic drive(input logic [2:0] sel, input int a, input logic [DW-1:0] d,
                       input logic [NL-1:0] en_n, input logic lw_n, input logic aw_n);
    {sel_a_n, sel_b, sel_c_n} = sel;
    addr = AW'(a); wdata = d; lane_en_n = en_n; lane_wr_n = lw_n; all_wr_n = aw_n;
  endtask

  // Issue one access, then wait two edges; returns valid seen after the second edge.
  task automatic access(input logic [2:0] sel, input int a, input logic [DW-1:0] d,
                        input logic [NL-1:0] en_n, input logic lw_n, input logic aw_n,
                        output logic vld);
    drive(sel, a, d, en_n, lw_n, aw_n);
    @(negedge clk);
    go_idle();
    @(negedge clk);
    vld = rdata_vld;
  endtask

  task automatic read_chk(input int a, input string req);
    drive(3'b010, a, '0, '1, 1'b1, 1'b1);
    @(negedge clk);
    check(rdata_vld == 1'b0, "R1 not valid after capture edge", 64'(rdata_vld), 64'd0);
    go_idle();
    @(negedge clk);
    check(rdata_vld == 1'b1, {req, " valid"}, 64'(rdata_vld), 64'd1);
    check(rdata == ref_mem[a], {req, " data"}, 64'(rdata), 64'(ref_mem[a]));
  endtask

  task automatic wr_full(input int a, input logic [DW-1:0] d);
    logic v;
    access(3'b010, a, d, '1, 1'b1, 1'b0, v);
    ref_mem[a] = d;
  endtask

  // Sleep two edges with a write attempt, then wake while reading addr a on every edge.
  task automatic sleep_wake(input int a);
    drive(3'b010, a, ~ref_mem[a], '1, 1'b1, 1'b0);
    sleep = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rdata_vld == 1'b0, "R8 asleep output invalid", 64'(rdata_vld), 64'd0);
    sleep = 1'b0;
    for (int i = 1; i <= WK + 3; i++) begin
      if (i <= WK) drive(3'b010, a, ~ref_mem[a], '1, 1'b1, 1'b0);
      else         drive(3'b010, a, '0, '1, 1'b1, 1'b1);
      @(negedge clk);
      check(rdata_vld == (i >= WK + 2), "R9 wake window valid", 64'(rdata_vld), 64'(i >= WK + 2));
      if (i >= WK + 2)
        check(rdata == ref_mem[a], "R10 sleep writes ignored", 64'(rdata), 64'(ref_mem[a]));
    end
    go_idle();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic v;
    go_idle();
    drive(3'b010, 0, '0, '1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check(rdata_vld == 1'b0 && rdata == '0, "R7 reset state", 64'(rdata), 64'd0);
    rst_n = 1'b1;
    // R9: reset acts as sleep; read held on every edge.
    for (int i = 1; i <= WK + 2; i++) begin
      @(negedge clk);
      check(rdata_vld == (i >= WK + 2), "R9 wake after reset", 64'(rdata_vld), 64'(i >= WK + 2));
    end
    go_idle();
    @(negedge clk);

    // R5: fill every word with a global write, then read all back.
    for (int a = 0; a < NW; a++) wr_full(a, word_of(a, 100));
    for (int a = 0; a < NW; a++) read_chk(a, "R5 global fill");

    // R3/R4/R5: all lane patterns against all strobe settings.
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 4; m++) begin
        int a;
        logic [DW-1:0] nv;
        logic [NL-1:0] msk;
        a = (p * 4 + m) % NW;
        wr_full(a, word_of(a, 200 + p));
        nv = word_of(a, 300 + p * 4 + m);
        msk = mask_of(NL'(p), m[0], m[1]);
        access(3'b010, a, nv, NL'(p), m[0], m[1], v);
        if (msk == '0)
          check(v == 1'b1, "R4 no lane chosen acts as read", 64'(v), 64'd1);
        else
          check(v == 1'b0, "R6 write gives no valid", 64'(v), 64'd0);
        ref_mem[a] = merge(ref_mem[a], nv, msk);
        if (!m[1])      read_chk(a, "R5 global override");
        else if (!m[0]) read_chk(a, "R3 lane merge");
        else            read_chk(a, "R4 lane enables ignored");
      end
    end

    // R6: write followed at once by a read of the same word.
    drive(3'b010, 5, word_of(5, 400), 4'b0101, 1'b0, 1'b1);
    ref_mem[5] = merge(ref_mem[5], word_of(5, 400), 4'b1010);
    @(negedge clk);
    drive(3'b010, 5, '0, '1, 1'b1, 1'b1);
    @(negedge clk);
    go_idle();
    @(negedge clk);
    check(rdata_vld && rdata == ref_mem[5], "R6 back-to-back read", 64'(rdata), 64'(ref_mem[5]));
    @(negedge clk);

    // R2: every non-selecting chip-select combination, read and write.
    for (int s = 0; s < 8; s++) begin
      if (s != 3'b010) begin
        access(3'(s), 7, '0, '1, 1'b1, 1'b1, v);
        check(v == 1'b0, "R2 deselected read", 64'(v), 64'd0);
        access(3'(s), 7, ~ref_mem[7], '1, 1'b1, 1'b0, v);
        read_chk(7, "R2 deselected write dropped");
      end
    end

    // R7: output enable gates without a clock.
    drive(3'b010, 9, '0, '1, 1'b1, 1'b1);
    @(negedge clk);
    go_idle();
    @(negedge clk);
    oe_n = 1'b1;
    #0.5;
    check(rdata_vld == 1'b0 && rdata == '0, "R7 oe high blanks", 64'(rdata), 64'd0);
    oe_n = 1'b0;
    #0.5;
    check(rdata_vld && rdata == ref_mem[9], "R7 oe low restores", 64'(rdata), 64'(ref_mem[9]));
    @(negedge clk);

    // R8/R9/R10: sleep and wake.
    sleep_wake(3);
    sleep_wake(12);

    // R8: sleep arriving while a read is in flight.
    drive(3'b010, 4, '0, '1, 1'b1, 1'b1);
    @(negedge clk);
    go_idle();
    sleep = 1'b1;
    @(negedge clk);
    check(rdata_vld == 1'b0, "R8 in-flight read dropped", 64'(rdata_vld), 64'd0);
    sleep = 1'b0;
    repeat (WK + 2) @(negedge clk);
    read_chk(4, "R9 access after wake");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule